// File: doc/BRIEF.md
# Flash Bulk Buffered Program Controller

This block is the device-side sequencer for a streaming bulk-programming mode of a NOR-style flash. A host sends a two-word command pair over a simple write bus. The second word carries the start address in the array. The controller then runs a fixed-length setup phase. In that phase it samples the block-lock and programming-voltage inputs and checks that the start address sits on a buffer boundary. Any fault sets error bits in the status register and returns the controller to idle.

Once setup passes, the host streams exactly one buffer of 32 words at a time. Every write the host makes while the mode is active is taken as data, even when its value equals a command code. When the buffer is full, the controller commits it word by word to a behavioural array port. Each word takes a fixed number of cycles. Each commit continues at the array address where the previous one stopped, and the address wraps inside the selected block. A write to an address outside the selected block during a fill ends the mode and drops the words loaded so far.

The host read bus always shows the status register. Bit 7 means ready (the mode is not running). Bit 4 means the mode failed. Bit 3 means the programming voltage was bad. Bit 1 means the block was locked. Bit 0 means the buffer cannot take a new fill. All other bits read 0.

Top module: `fbp_ctrl`

## Requirements
- R1: After reset the status reads 0x0080 (ready, no errors, buffer free), and arr_we stays low.
- R2: In idle, a write of 0x0080 followed by a write of 0x00D0 starts the mode. The address of the second write is the start address. On the next cycle bit 7 is clear and bit 0 is set. If the second write is any other value, the controller returns to idle, and a lone 0x00D0 has no effect.
- R3: After SETUP_CYC cycles of setup, the controller samples blk_locked and vpp_ok. A locked block sets bits 4 and 1. A bad voltage sets bits 4 and 3. Either fault ends the mode with bit 7 set. The error bits stay set until the next accepted command pair clears them.
- R4: A start address whose five low bits are not zero ends setup with bit 4 set and bits 3 and 1 clear.
- R5: While a fill is in progress, every write whose address lies in the selected block is stored as buffer data, including the values 0x0080, 0x00D0 and 0x0070. The address itself does not pick the slot.
- R6: A fill stores words into slots 0 to 31 in arrival order, and the status reads 0x0000 while a fill is open. From the 32nd write until the last word is committed, the status reads 0x0001. Host writes made during a commit are ignored.
- R7: A commit raises arr_we for one cycle per word, with the words PROG_CYC cycles apart, in slot order. The first commit starts at the start address. Each later commit continues where the previous one stopped. The address wraps from the top of the block back to its base.
- R8: During a fill, a write whose address is outside the selected block ends the mode. The status becomes 0x0080, and no word of the partial buffer is written to the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write strobe, one word per cycle |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | WORD_W | Host write data or command code |
| host_rdata | output | WORD_W | Status register, always presented |
| blk_locked | input | 1 | Lock state of the addressed block, sampled at the end of setup |
| vpp_ok | input | 1 | Programming voltage within range, sampled at the end of setup |
| arr_we | output | 1 | One-cycle strobe that starts programming one word |
| arr_addr | output | ADDR_W | Array word address for arr_we |
| arr_wdata | output | WORD_W | Array word data for arr_we |

## Verification
The bench builds the block with BLK_WORDS = 64, PROG_CYC = 3 and SETUP_CYC = 4. The buffer depth stays at 32 words.

With a 64-word block and a start at offset 32, the second commit has to wrap to the block base. This puts the wrap case within two buffers. The short setup and programming latencies keep every error run, the out-of-block exit and the word-spacing checks to a few hundred cycles.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONF,
        ST_SETUP,
        ST_FILL,
        ST_PROG
    } fbp_state_e;

    // status register bit positions seen by the host
    localparam int SR_READY = 7;
    localparam int SR_FAIL  = 4;
    localparam int SR_VOLT  = 3;
    localparam int SR_LOCK  = 1;
    localparam int SR_BUSY  = 0;

endpackage

// File: rtl/fbp_wbuf.sv
// Word staging buffer: one write port indexed by the fill slot and one
// combinational read port indexed by the commit word.
module fbp_wbuf #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     ridx,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (widx == AW'(g))) begin
                slot_q[g] <= wdata;
            end
        end
    end

    assign rdata = slot_q[ridx];

endmodule

// File: rtl/fbp_addr_ctr.sv
// Block-relative array address counter: holds the selected block number and
// the word offset inside it; the offset wraps at the top of the block.
module fbp_addr_ctr #(
    parameter int ADDR_W    = 16,
    parameter int BLK_WORDS = 1024,
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int BLK_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [BLK_W-1:0]  blk_o,
    output logic [OFF_W-1:0]  off_o
);

    typedef struct packed {
        logic [BLK_W-1:0] blk;
        logic [OFF_W-1:0] off;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.blk = load_addr[ADDR_W-1:OFF_W];
            c_d.off = load_addr[OFF_W-1:0];
        end else if (step) begin
            if (c_q.off == OFF_W'(BLK_WORDS - 1)) begin
                c_d.off = '0;
            end else begin
                c_d.off = c_q.off + OFF_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign blk_o = c_q.blk;
    assign off_o = c_q.off;

endmodule

// File: rtl/fbp_ctrl.sv
// Bulk buffered program controller: command pair decode, setup checks,
// 32-word fill / commit loop and host-visible status register.
module fbp_ctrl
    import fbp_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          WORD_W      = 16,
    parameter int          BLK_WORDS   = 1024,
    parameter int          BUF_WORDS   = 32,
    parameter int          PROG_CYC    = 4,
    parameter int          SETUP_CYC   = 8,
    parameter logic [15:0] CMD_SETUP   = 16'h0080,
    parameter logic [15:0] CMD_CONFIRM = 16'h00D0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              blk_locked,
    input  logic              vpp_ok,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [WORD_W-1:0] arr_wdata
);

    localparam int OFF_W   = $clog2(BLK_WORDS);
    localparam int BLK_W   = ADDR_W - OFF_W;
    localparam int IDX_W   = $clog2(BUF_WORDS);
    localparam int CYC_MAX = (SETUP_CYC > PROG_CYC) ? SETUP_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(CYC_MAX + 1);

    typedef struct packed {
        fbp_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic             err_fail;
        logic             err_volt;
        logic             err_lock;
    } ctl_t;

    ctl_t r_d, r_q;

    logic              buf_we;
    logic [WORD_W-1:0] buf_rdata;
    logic              ac_load;
    logic              ac_step;
    logic [BLK_W-1:0]  ac_blk;
    logic [OFF_W-1:0]  ac_off;
    logic              in_blk;
    logic              misaligned;
    fbp_state_e        st_q;

    assign st_q       = r_q.st;
    assign in_blk     = (host_addr[ADDR_W-1:OFF_W] == ac_blk);
    assign misaligned = (ac_off[IDX_W-1:0] != '0);

    always_comb begin
        r_d     = r_q;
        buf_we  = 1'b0;
        ac_load = 1'b0;
        ac_step = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (host_we && host_wdata == WORD_W'(CMD_SETUP)) begin
                    r_d.st = ST_CONF;
                end
            end
            ST_CONF: begin
                if (host_we) begin
                    if (host_wdata == WORD_W'(CMD_CONFIRM)) begin
                        r_d.st       = ST_SETUP;
                        r_d.cnt      = '0;
                        r_d.err_fail = 1'b0;
                        r_d.err_volt = 1'b0;
                        r_d.err_lock = 1'b0;
                        ac_load      = 1'b1;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == CNT_W'(SETUP_CYC - 1)) begin
                    r_d.err_lock = blk_locked;
                    r_d.err_volt = !vpp_ok;
                    r_d.err_fail = blk_locked || !vpp_ok || misaligned;
                    r_d.idx      = '0;
                    r_d.cnt      = '0;
                    if (blk_locked || !vpp_ok || misaligned) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.st = ST_FILL;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_FILL: begin
                if (host_we) begin
                    if (!in_blk) begin
                        r_d.st  = ST_IDLE;
                        r_d.idx = '0;
                    end else begin
                        buf_we = 1'b1;
                        if (r_q.idx == IDX_W'(BUF_WORDS - 1)) begin
                            r_d.st  = ST_PROG;
                            r_d.idx = '0;
                            r_d.cnt = '0;
                        end else begin
                            r_d.idx = r_q.idx + IDX_W'(1);
                        end
                    end
                end
            end
            ST_PROG: begin
                if (r_q.cnt == CNT_W'(PROG_CYC - 1)) begin
                    r_d.cnt = '0;
                    ac_step = 1'b1;
                    if (r_q.idx == IDX_W'(BUF_WORDS - 1)) begin
                        r_d.st  = ST_FILL;
                        r_d.idx = '0;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    fbp_wbuf #(
        .WORD_W (WORD_W),
        .DEPTH  (BUF_WORDS)
    ) u_wbuf (
        .clk   (clk),
        .we    (buf_we),
        .widx  (r_q.idx),
        .wdata (host_wdata),
        .ridx  (r_q.idx),
        .rdata (buf_rdata)
    );

    fbp_addr_ctr #(
        .ADDR_W    (ADDR_W),
        .BLK_WORDS (BLK_WORDS)
    ) u_actr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ac_load),
        .load_addr (host_addr),
        .step      (ac_step),
        .blk_o     (ac_blk),
        .off_o     (ac_off)
    );

    always_comb begin
        host_rdata           = '0;
        host_rdata[SR_READY] = (r_q.st == ST_IDLE) || (r_q.st == ST_CONF);
        host_rdata[SR_FAIL]  = r_q.err_fail;
        host_rdata[SR_VOLT]  = r_q.err_volt;
        host_rdata[SR_LOCK]  = r_q.err_lock;
        host_rdata[SR_BUSY]  = (r_q.st == ST_SETUP) || (r_q.st == ST_PROG);
    end

    assign arr_we    = (r_q.st == ST_PROG) && (r_q.cnt == '0);
    assign arr_addr  = {ac_blk, ac_off};
    assign arr_wdata = buf_rdata;

endmodule

// File: rtl/fbp_ctrl_chk.sv
module fbp_ctrl_chk
    import fbp_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          WORD_W      = 16,
    parameter int          OFF_W       = 10,
    parameter logic [15:0] CMD_CONFIRM = 16'h00D0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     host_we,
    input logic [ADDR_W-1:0]        host_addr,
    input logic [WORD_W-1:0]        host_wdata,
    input logic [WORD_W-1:0]        host_rdata,
    input logic                     arr_we,
    input logic [ADDR_W-1:0]        arr_addr,
    input fbp_state_e               st,
    input logic [ADDR_W-OFF_W-1:0]  blk
);

    AST_CONFIRM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CONF && host_we && host_wdata == WORD_W'(CMD_CONFIRM))
        |=> (!host_rdata[SR_READY] && host_rdata[SR_BUSY])); // R2

    AST_FAIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_rdata[SR_FAIL]) |-> host_rdata[SR_READY]); // R3

    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (host_rdata[SR_BUSY] && !host_rdata[SR_READY])); // R6

    AST_WRITE_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_addr[ADDR_W-1:OFF_W] == blk)); // R7

    AST_OUT_OF_BLOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL && host_we && host_addr[ADDR_W-1:OFF_W] != blk)
        |=> (host_rdata[SR_READY] && !host_rdata[SR_FAIL] && !arr_we)); // R8

endmodule

bind fbp_ctrl fbp_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .WORD_W      (WORD_W),
    .OFF_W       (OFF_W),
    .CMD_CONFIRM (CMD_CONFIRM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr),
    .st         (st_q),
    .blk        (ac_blk)
);

// File: tb/fbp_ctrl_test.sv
module fbp_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int WORD_W     = 16;
    localparam int BLK_WORDS  = 64;
    localparam int BUF_WORDS  = 32;
    localparam int PROG_CYC   = 3;
    localparam int SETUP_CYC  = 4;
    localparam logic [15:0] BASE = 16'h0080;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [WORD_W-1:0] host_wdata = '0;
    logic [WORD_W-1:0] host_rdata;
    logic              blk_locked = 1'b0;
    logic              vpp_ok = 1'b1;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [WORD_W-1:0] arr_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    int n_pulse = 0;
    int cyc = 0;
    int last_pulse_cyc = 0;
    bit done = 1'b0;
    logic [31:0] sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fbp_ctrl #(
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .BLK_WORDS (BLK_WORDS),
        .BUF_WORDS (BUF_WORDS),
        .PROG_CYC  (PROG_CYC),
        .SETUP_CYC (SETUP_CYC)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .blk_locked (blk_locked),
        .vpp_ok     (vpp_ok),
        .arr_we     (arr_we),
        .arr_addr   (arr_addr),
        .arr_wdata  (arr_wdata)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // monitor: pops the scoreboard on every array write strobe
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            if (n_pulse % BUF_WORDS != 0) begin
                check("R7 word spacing", 32'(cyc - last_pulse_cyc), 32'(PROG_CYC));
            end
            last_pulse_cyc = cyc;
            n_pulse++;
            if (sb_q.size() == 0) begin
                check("R8 unexpected array write", {arr_addr, arr_wdata}, 32'hxxxx_xxxx);
            end else begin
                check("R7 array write", {arr_addr, arr_wdata}, sb_q.pop_front());
            end
        end
    end

    task automatic wr(logic [15:0] a, logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(logic [15:0] a);
        wr(16'h1234, 16'h0080);
        wr(a, 16'h00D0);
    endtask

    function automatic logic [15:0] word_of(int seed, int i);
        if (i == 3) return 16'h0080;
        if (i == 4) return 16'h00D0;
        if (i == 5) return 16'h0070;
        return 16'(seed * 16'h0101 + i * 7);
    endfunction

    // driver: streams one full buffer and pushes the expected array writes
    task automatic fill_buffer(int seed, int off);
        for (int i = 0; i < BUF_WORDS; i++) begin
            logic [15:0] d;
            d = word_of(seed, i);
            sb_q.push_back({BASE + 16'((off + i) % BLK_WORDS), d});
            wr(BASE + 16'((i * 5) % BLK_WORDS), d);   // R5: address does not pick the slot
        end
    endtask

    task automatic wait_buf_free();
        for (int k = 0; k < 1000; k++) begin
            if (!host_rdata[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int pulses_before;
        wait_cyc(3);
        check("R1 reset status", 32'(host_rdata), 32'h0080);
        check("R1 reset arr_we", 32'(arr_we), 32'h0);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 status after reset", 32'(host_rdata), 32'h0080);

        // lock error
        blk_locked = 1'b1;
        start(BASE);
        check("R2 busy after confirm", 32'(host_rdata), 32'h0001);
        wait_cyc(SETUP_CYC + 1);
        check("R3 locked", 32'(host_rdata), 32'h0092);
        // voltage error; lock flag from before must clear
        blk_locked = 1'b0; vpp_ok = 1'b0;
        start(BASE);
        wait_cyc(SETUP_CYC + 1);
        check("R3 bad voltage", 32'(host_rdata), 32'h0098);
        blk_locked = 1'b1;
        start(BASE);
        wait_cyc(SETUP_CYC + 1);
        check("R3 both faults", 32'(host_rdata), 32'h009A);
        blk_locked = 1'b0; vpp_ok = 1'b1;

        // misaligned start
        start(BASE + 16'd5);
        wait_cyc(SETUP_CYC + 1);
        check("R4 misaligned", 32'(host_rdata), 32'h0090);

        // wrong confirm, then a lone confirm
        wr(16'h0000, 16'h0080);
        wr(BASE, 16'h0070);
        check("R2 bad confirm idle", 32'(host_rdata), 32'h0090);
        wr(BASE, 16'h00D0);
        wait_cyc(SETUP_CYC + 1);
        check("R2 lone confirm ignored", 32'(host_rdata), 32'h0090);

        // good run starting at offset 32, second buffer wraps
        start(BASE + 16'd32);
        wait_cyc(SETUP_CYC + 1);
        check("R6 fill status", 32'(host_rdata), 32'h0000);
        fill_buffer(1, 32);
        check("R6 commit status", 32'(host_rdata), 32'h0001);
        wr(BASE + 16'd1, 16'hDEAD);   // R6: ignored during commit
        wait_buf_free();
        check("R6 buffer free again", 32'(host_rdata), 32'h0000);
        check("R7 first buffer drained", 32'(sb_q.size()), 32'h0);
        fill_buffer(2, 0);
        wait_buf_free();
        check("R7 wrapped buffer drained", 32'(sb_q.size()), 32'h0);
        check("R7 pulse count", 32'(n_pulse), 32'(2 * BUF_WORDS));

        // partial fill then out-of-block write
        pulses_before = n_pulse;
        for (int i = 0; i < 10; i++) wr(BASE + 16'(i), 16'hA500 + 16'(i));
        check("R8 partial fill status", 32'(host_rdata), 32'h0000);
        wr(16'h0000, 16'h5555);
        check("R8 exit status", 32'(host_rdata), 32'h0080);
        wait_cyc(200);
        check("R8 nothing programmed", 32'(n_pulse), 32'(pulses_before));
        check("R8 still idle", 32'(host_rdata), 32'h0080);

        finish_run();
    end

endmodule